// File: doc/BRIEF.md
# Whole-Frame Receive Admission Gate

This block sits between the receive side of an Ethernet MAC and the DMA engine that empties the receive buffer. It keeps a count of the complete frames held in that buffer. For every incoming frame it decides, at the frame's start strobe, whether the whole frame is kept or thrown away. A frame is refused only when the buffer already holds its full quota of frames. The refused frame is dropped in its entirety, and the frames already held stay untouched until the DMA side drains them.

Each refusal adds one to a saturating missed-frame tally and sets a sticky overflow flag. Software clears that flag with a write-1-to-clear pulse. The flag drives an interrupt line through an enable bit. The data storage, the descriptors and the MAC framing all live elsewhere. This block only makes the admission decision and keeps the counts and the status.

Top module: `rx_frame_admit`

## Requirements
- R1: After a synchronous reset, the frame count, the overflow flag, the missed tally, the interrupt and the decision-valid output are all 0.
- R2: A start strobe seen while fewer than 8 frames are held produces, one cycle later, a one-cycle decision with valid=1 and admit=1. The end strobe of an admitted frame raises the count by one in the cycle after that end strobe.
- R3: A start strobe seen while 8 frames are held produces, one cycle later, a decision with valid=1 and admit=0. The end strobe of that dropped frame leaves the count unchanged.
- R4: A drain strobe lowers the count by one in the following cycle. A drain strobe at count 0 is ignored and the count stays 0.
- R5: When a stored frame ends in the same cycle as a drain, the count keeps its value.
- R6: A drop leaves the 8 held frames counted. After one drain, the next start strobe is admitted.
- R7: A drop sets the overflow flag in the next cycle. The flag stays set until a clear pulse, and it reads 0 in the cycle after that pulse.
- R8: When a drop and a clear pulse occur in the same cycle, the flag is 1 afterwards.
- R9: The 16-bit missed tally rises by one per dropped frame, visible the cycle after the drop. It holds at 65535 once it gets there. Its clear input sets it to 0. A clear in the same cycle as a drop leaves it at 1.
- R10: The interrupt output equals the overflow flag ANDed with the enable input, with no register in between.
- R11: The decision counts a stored frame whose end strobe coincides with the start strobe. At 7 held frames, an end and a start in the same cycle drop the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Incoming frame start strobe |
| eof_i | input | 1 | Incoming frame end strobe |
| drain_i | input | 1 | One held frame moved to memory by DMA |
| ovf_clr_i | input | 1 | Write-1-to-clear pulse for the overflow flag |
| miss_clr_i | input | 1 | Clears the missed-frame tally |
| irq_en_i | input | 1 | Overflow interrupt enable |
| dec_valid_o | output | 1 | One-cycle pulse marking an admission decision |
| dec_admit_o | output | 1 | 1 = frame kept, 0 = frame dropped; meaningful with dec_valid_o |
| frame_cnt_o | output | 4 | Complete frames currently held (0 to 8) |
| ovf_flag_o | output | 1 | Sticky overflow status |
| irq_o | output | 1 | Overflow interrupt request |
| miss_cnt_o | output | 16 | Saturating missed-frame tally |

## Verification
The decision, the count, the flag and the tally all come from registers, so each one is due exactly one clock after the strobe that causes it. The interrupt is combinational and follows the enable input within the same cycle. The driver task applies one cycle of strobes and then computes that cycle's expected state from the requirements. It pushes this state to a queue, and the monitor pops and compares it on the falling edge right after that clock. The interrupt is checked directly on a falling edge once the enable has settled.

// File: rtl/rx_admit_pkg.sv
package rx_admit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STORE   = 2'd1,
        ST_DISCARD = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic valid;
        logic admit;
    } rx_decision_t;

    typedef struct packed {
        logic frame_done;
        logic frame_drop;
    } rx_event_t;

endpackage

// File: rtl/rx_admit_ctrl.sv
module rx_admit_ctrl
    import rx_admit_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof_i,
    input  logic             eof_i,
    input  logic [CNT_W-1:0] cnt_i,
    output rx_decision_t     dec_o,
    output rx_event_t        ev_o
);

    localparam logic [CNT_W:0] FULL = (CNT_W + 1)'(DEPTH);

    rx_state_e    state_q, state_d;
    rx_decision_t dec_q;
    logic [CNT_W:0] occ;
    logic         done, drop;

    // A frame finishing at this edge already occupies a slot.
    always_comb begin
        done = eof_i && (state_q == ST_STORE);
        occ  = {1'b0, cnt_i} + (CNT_W + 1)'(done);
        drop = sof_i && (occ >= FULL);
    end

    always_comb begin
        state_d = state_q;
        if (sof_i)
            state_d = drop ? ST_DISCARD : ST_STORE;
        else if (eof_i)
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dec_q   <= '0;
        end else begin
            state_q     <= state_d;
            dec_q.valid <= sof_i;
            dec_q.admit <= sof_i && !drop;
        end
    end

    assign dec_o         = dec_q;
    assign ev_o.frame_done = done;
    assign ev_o.frame_drop = drop;

    AST_ADMIT_WITH_ROOM: assert property (@(posedge clk) disable iff (rst)
        (sof_i && occ < FULL) |=> (dec_q.valid && dec_q.admit)); // R2
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (sof_i && occ >= FULL) |=> (dec_q.valid && !dec_q.admit)); // R3
    AST_DISCARD_NOT_COUNTED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DISCARD && eof_i) |-> !ev_o.frame_done); // R3

endmodule

// File: rtl/rx_frame_counter.sv
module rx_frame_counter #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done_i,
    input  logic             drain_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic             inc, dec;

    always_comb begin
        inc = done_i && (cnt_q != TOP);
        dec = drain_i && (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (inc && !dec)
            cnt_q <= cnt_q + 1'b1;
        else if (dec && !inc)
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o = cnt_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP); // R2
    AST_EMPTY_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && drain_i && !done_i) |=> (cnt_q == '0)); // R4
    AST_END_AND_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (done_i && drain_i && cnt_q != '0) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/rx_overflow_status.sv
module rx_overflow_status #(
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drop_i,
    input  logic              ovf_clr_i,
    input  logic              miss_clr_i,
    input  logic              irq_en_i,
    output logic              flag_o,
    output logic              irq_o,
    output logic [MISS_W-1:0] miss_o
);

    localparam logic [MISS_W-1:0] MISS_MAX = '1;

    logic              flag_q;
    logic [MISS_W-1:0] miss_q, miss_base;

    always_comb miss_base = miss_clr_i ? '0 : miss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            miss_q <= '0;
        end else begin
            // A new overflow wins over a clear in the same cycle.
            flag_q <= drop_i || (flag_q && !ovf_clr_i);
            miss_q <= (drop_i && miss_base != MISS_MAX) ? miss_base + 1'b1 : miss_base;
        end
    end

    assign flag_o = flag_q;
    assign miss_o = miss_q;
    assign irq_o  = flag_q && irq_en_i;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !ovf_clr_i) |=> flag_q); // R7
    AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        drop_i |=> flag_q); // R8
    AST_MISS_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (miss_q == MISS_MAX && !miss_clr_i) |=> (miss_q == MISS_MAX)); // R9
    AST_MISS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (miss_clr_i && !drop_i) |=> (miss_q == '0)); // R9

endmodule

// File: rtl/rx_frame_admit.sv
module rx_frame_admit
    import rx_admit_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int MISS_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sof_i,
    input  logic              eof_i,
    input  logic              drain_i,
    input  logic              ovf_clr_i,
    input  logic              miss_clr_i,
    input  logic              irq_en_i,
    output logic              dec_valid_o,
    output logic              dec_admit_o,
    output logic [CNT_W-1:0]  frame_cnt_o,
    output logic              ovf_flag_o,
    output logic              irq_o,
    output logic [MISS_W-1:0] miss_cnt_o
);

    rx_decision_t     dec;
    rx_event_t        ev;
    logic [CNT_W-1:0] cnt;

    rx_admit_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .sof_i (sof_i),
        .eof_i (eof_i),
        .cnt_i (cnt),
        .dec_o (dec),
        .ev_o  (ev)
    );

    rx_frame_counter #(.DEPTH(DEPTH)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .done_i  (ev.frame_done),
        .drain_i (drain_i),
        .cnt_o   (cnt)
    );

    rx_overflow_status #(.MISS_W(MISS_W)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .drop_i     (ev.frame_drop),
        .ovf_clr_i  (ovf_clr_i),
        .miss_clr_i (miss_clr_i),
        .irq_en_i   (irq_en_i),
        .flag_o     (ovf_flag_o),
        .irq_o      (irq_o),
        .miss_o     (miss_cnt_o)
    );

    assign dec_valid_o = dec.valid;
    assign dec_admit_o = dec.admit;
    assign frame_cnt_o = cnt;

    AST_HELD_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (ev.frame_drop && !drain_i) |=> (frame_cnt_o == CNT_W'(DEPTH))); // R6

endmodule

// File: tb/rx_frame_admit_tb.sv
`timescale 1ns/1ps
module rx_frame_admit_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sof = 0, eof = 0, drn = 0, oclr = 0, mclr = 0, irq_en = 0;
    logic dv, da, flag, irq;
    logic [3:0]  cnt;
    logic [15:0] miss;

    always #5 clk = ~clk;

    rx_frame_admit u_dut (
        .clk(clk), .rst(rst), .sof_i(sof), .eof_i(eof), .drain_i(drn),
        .ovf_clr_i(oclr), .miss_clr_i(mclr), .irq_en_i(irq_en),
        .dec_valid_o(dv), .dec_admit_o(da), .frame_cnt_o(cnt),
        .ovf_flag_o(flag), .irq_o(irq), .miss_cnt_o(miss)
    );

    typedef struct {
        logic [3:0]  cnt;
        logic        flag;
        logic [15:0] miss;
        logic        dv;
        logic        da;
        string       req;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    // requirement model
    int  m_cnt = 0;
    bit  m_store = 0, m_flag = 0;
    int  m_miss = 0;

    task automatic step(input bit s, input bit e, input bit d,
                        input bit oc, input bit mc, input string req);
        exp_t x;
        int occ;
        bit inc, dec, drop;
        sof = s; eof = e; drn = d; oclr = oc; mclr = mc;
        @(posedge clk);
        #1;
        inc  = e && m_store;
        dec  = d && (m_cnt > 0);
        occ  = m_cnt + (inc ? 1 : 0);
        drop = s && (occ >= 8);
        m_cnt = m_cnt + (inc ? 1 : 0) - (dec ? 1 : 0);
        if (s) m_store = !drop;
        else if (e) m_store = 0;
        m_flag = drop || (m_flag && !oc);
        if (mc) m_miss = 0;
        if (drop && m_miss != 65535) m_miss = m_miss + 1;
        x.cnt = 4'(m_cnt); x.flag = m_flag; x.miss = 16'(m_miss);
        x.dv = s; x.da = s && !drop; x.req = req;
        q.push_back(x);
        sof = 0; eof = 0; drn = 0; oclr = 0; mclr = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            checks++;
            if (cnt !== x.cnt || flag !== x.flag || miss !== x.miss ||
                dv !== x.dv || (x.dv && da !== x.da)) begin
                errors++;
                $display("FAIL %s: got cnt=%0d flag=%0b miss=%0d dv=%0b da=%0b exp cnt=%0d flag=%0b miss=%0d dv=%0b da=%0b",
                         x.req, cnt, flag, miss, dv, da, x.cnt, x.flag, x.miss, x.dv, x.da);
            end
        end
    end

    task automatic check_irq(input logic en, input logic exp_v, input string req);
        irq_en = en;
        @(negedge clk);
        checks++;
        if (irq !== exp_v) begin
            errors++;
            $display("FAIL %s: irq got %0b exp %0b", req, irq, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(150000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (cnt !== 0 || flag !== 0 || miss !== 0 || irq !== 0 || dv !== 0) begin
            errors++;
            $display("FAIL R1: got cnt=%0d flag=%0b miss=%0d irq=%0b dv=%0b exp all 0",
                     cnt, flag, miss, irq, dv);
        end
        @(posedge clk); #1 rst = 0;

        // R2: fill eight frames, with idle gaps between some
        for (int i = 0; i < 8; i++) begin
            step(1, 0, 0, 0, 0, "R2 admit");
            if (i % 2 == 0) step(0, 0, 0, 0, 0, "R2 mid-frame");
            step(0, 1, 0, 0, 0, "R2 frame end");
        end
        // R3: full buffer drops a whole frame
        step(1, 0, 0, 0, 0, "R3 drop");
        step(0, 0, 0, 0, 0, "R3 dropped body");
        step(0, 1, 0, 0, 0, "R3 dropped end");
        // R10: interrupt gating
        check_irq(1, 1, "R10 enabled");
        check_irq(0, 0, "R10 disabled");
        // R6: held frames intact, room after one drain
        step(0, 0, 1, 0, 0, "R6 drain");
        step(1, 0, 0, 0, 0, "R6 admit after drain");
        // R5: end + drain together
        step(0, 1, 1, 0, 0, "R5 end with drain");
        // R11: at 7, admitted frame ends as next starts
        step(1, 0, 0, 0, 0, "R11 admit at 7");
        step(1, 1, 0, 0, 0, "R11 end with start");
        step(0, 1, 0, 0, 0, "R11 dropped end");
        // R8: drop with clear
        step(1, 0, 0, 1, 0, "R8 drop with clear");
        step(0, 1, 0, 0, 0, "R8 end");
        // R7: clear alone
        step(0, 0, 0, 1, 0, "R7 clear");
        check_irq(1, 0, "R10 cleared flag");
        irq_en = 0;
        // R4: drain everything, then drain at empty
        for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0, "R4 drain");
        step(0, 0, 1, 0, 0, "R4 drain at empty");
        step(0, 0, 1, 0, 0, "R4 drain at empty again");
        // R9: clear, refill, saturate
        step(0, 0, 0, 0, 1, "R9 clear");
        for (int i = 0; i < 8; i++) begin
            step(1, 0, 0, 0, 0, "R2 refill");
            step(0, 1, 0, 0, 0, "R2 refill end");
        end
        for (int i = 0; i < 65540; i++) step(1, 0, 0, 0, 0, "R9 saturate");
        step(1, 0, 0, 0, 1, "R9 clear with drop");
        step(0, 0, 0, 0, 1, "R9 clear alone");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule